// File: doc/BRIEF.md
# I2C Command-Stream Transaction Sequencer

This block is the protocol core of an I2C controller. It reads a stream of 11-bit command words from a show-ahead queue, and each word moves exactly one data byte on the bus. A word either supplies a byte to send or asks for one byte to be received. It can also ask for a repeated START before its byte and a STOP after it. A complete multi-message transfer is therefore written into one command stream, with the message boundaries carried in the words themselves.

The sequencer adds the address phases itself. It sends START and the target address before the first byte of a transaction, and again after every repeated START, whether a word asked for it or a change of direction forced it. The target address comes from a 10-bit input, and a separate mode input selects 7-bit or 10-bit addressing. Received bytes are handed out one per pulse to an external receive queue. A one-cycle completion pulse closes every transaction. When the target does not acknowledge, an error pulse comes first, the bus is stopped, and the rest of the transaction's commands are discarded.

Bus timing is not generated here. Every step of SCL and SDA waits for one cycle of a step strobe, so an outside divider sets the bit rate. Both bus outputs are open-drain style: 1 releases the line and 0 pulls it low.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, SCL and SDA are both released (1), and no pop, receive push, completion or error pulse is given until a command is present.
- R2: Command word fields: bits [7:0] hold the byte to send, bit 8 set means receive one byte (bits [7:0] are then ignored), bit 9 requests STOP after the byte, and bit 10 requests a repeated START before it. The word is popped when its byte starts.
- R3: In 7-bit mode (addr_ten = 0), a transaction opens with START followed by the address byte {tgt_addr[6:0], R/W}, where R/W is bit 8 of the first command.
- R4: In 10-bit mode, a write sends START, the header 11110 tgt_addr[9:8] 0, then tgt_addr[7:0]. A read sends those same two bytes, then a repeated START and the header 11110 tgt_addr[9:8] 1.
- R5: A later command whose bit 10 is set, or whose bit 8 differs from the current direction, causes a repeated START and a new address phase before its byte. Bit 10 is ignored on the first byte after an address phase.
- R6: On a receive byte, SDA is released for the 8 data bits, and the byte is presented on rx_data with a one-cycle rx_push. The sequencer answers NACK if that word carries the STOP flag and ACK otherwise.
- R7: After the byte of a word with the STOP flag, a STOP condition is sent and done_evt pulses for one cycle, with both lines released.
- R8: A NACK on an address byte or on a sent data byte raises err_evt. The sequencer then sends STOP and pops and discards commands up to and including the next one with the STOP flag. Only after that does done_evt pulse.
- R9: If the queue is empty while a transaction is open (no STOP sent yet), SCL is held low and no STOP is sent until a command arrives.
- R10: cmd_pop is asserted only while cmd_valid is high. done_evt, err_evt and rx_push never pulse in the same cycle.
- R11: SCL and SDA change only in the cycle after step_tick was high. With the strobe held low, the bus is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_tick | input | 1 | Bus step strobe; one bus step per high cycle |
| cmd_valid | input | 1 | Command queue not empty |
| cmd_word | input | 11 | Head of the command queue (show-ahead) |
| cmd_pop | output | 1 | Removes the head command |
| tgt_addr | input | 10 | Target address |
| addr_ten | input | 1 | 1 selects 10-bit addressing |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| sda_i | input | 1 | Sensed SDA line |
| rx_push | output | 1 | Received byte valid, one cycle |
| rx_data | output | 8 | Received byte |
| done_evt | output | 1 | Transaction complete pulse |
| err_evt | output | 1 | NACK error pulse |

## Verification
The main function is exercised in three ways. First, single-word transactions with varied addresses, data extremes and both directions check the basic address-and-byte framing. Second, multi-word streams isolate the two causes of a repeated START: a flag in the word, or a change of direction. Third, 10-bit writes and reads confirm that the extra header and its repeated START appear only on reads. A bus-side target model logs every START, STOP, byte and acknowledge bit. NACKs are injected on the address byte and on a later data byte to tell the flush path from normal termination. An empty-queue pause and a frozen strobe show that the bus waits instead of closing or moving on.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 10;
  localparam int CMD_W   = BYTE_W + 3;
  localparam int CB_RD   = BYTE_W;
  localparam int CB_STOP = BYTE_W + 1;
  localparam int CB_RS   = BYTE_W + 2;
  localparam int BIT_CW  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    SYM_NONE, SYM_START, SYM_RSTART, SYM_STOP, SYM_BYTE
  } sym_e;

  typedef enum logic [3:0] {
    S_IDLE, S_STA, S_AD1, S_AD2, S_RS10, S_AD3, S_NEXT, S_RSC, S_DAT, S_STP, S_FLS
  } seq_e;
endpackage

// File: rtl/i2cseq_bus_eng.sv
module i2cseq_bus_eng
  import i2cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  sym_e              op,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              rd_mode,
  input  logic              ack_val,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              done,
  output logic              ack_in,
  output logic              idle,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [BIT_CW-1:0] ACK_IDX = BIT_CW'(BYTE_W);

  sym_e              st_q, st_n;
  logic [1:0]        sub_q, sub_n;
  logic [BIT_CW-1:0] bit_q, bit_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              scl_q, scl_n, sda_q, sda_n;
  logic              done_q, done_n, ack_q, ack_n;
  logic              rd_q, rd_n, av_q, av_n;
  logic              fin;

  always_comb begin
    st_n = st_q;  sub_n = sub_q; bit_n = bit_q; sh_n = sh_q;
    scl_n = scl_q; sda_n = sda_q; ack_n = ack_q; rd_n = rd_q; av_n = av_q;
    fin = 1'b0;
    if (st_q == SYM_NONE) begin
      if (go) begin
        st_n = op; sub_n = '0; bit_n = '0;
        sh_n = tx_byte; rd_n = rd_mode; av_n = ack_val;
      end
    end else if (tick) begin
      sub_n = sub_q + 2'd1;
      case (st_q)
        SYM_START: begin
          if (sub_q == 2'd0) sda_n = 1'b0;
          else begin scl_n = 1'b0; fin = 1'b1; end
        end
        SYM_RSTART: begin
          case (sub_q)
            2'd0:    sda_n = 1'b1;
            2'd1:    scl_n = 1'b1;
            2'd2:    sda_n = 1'b0;
            default: begin scl_n = 1'b0; fin = 1'b1; end
          endcase
        end
        SYM_STOP: begin
          case (sub_q)
            2'd0:    sda_n = 1'b0;
            2'd1:    scl_n = 1'b1;
            default: begin sda_n = 1'b1; fin = 1'b1; end
          endcase
        end
        default: begin
          case (sub_q)
            2'd0: begin
              if (bit_q == ACK_IDX) sda_n = rd_q ? av_q : 1'b1;
              else                  sda_n = rd_q ? 1'b1 : sh_q[BYTE_W-1];
            end
            2'd1: scl_n = 1'b1;
            default: begin
              scl_n = 1'b0;
              sub_n = '0;
              if (bit_q == ACK_IDX) begin
                ack_n = sda_i;
                fin   = 1'b1;
              end else begin
                sh_n  = {sh_q[BYTE_W-2:0], sda_i};
                bit_n = bit_q + 1'b1;
              end
            end
          endcase
        end
      endcase
    end
    if (fin) st_n = SYM_NONE;
    done_n = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SYM_NONE; sub_q <= '0; bit_q <= '0; sh_q <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1; done_q <= 1'b0; ack_q <= 1'b0;
      rd_q <= 1'b0; av_q <= 1'b0;
    end else begin
      st_q <= st_n; sub_q <= sub_n; bit_q <= bit_n; sh_q <= sh_n;
      scl_q <= scl_n; sda_q <= sda_n; done_q <= done_n; ack_q <= ack_n;
      rd_q <= rd_n; av_q <= av_n;
    end
  end

  assign scl_o   = scl_q;
  assign sda_o   = sda_q;
  assign done    = done_q;
  assign ack_in  = ack_q;
  assign idle    = (st_q == SYM_NONE);
  assign rx_byte = sh_q;

  // R11
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(scl_o) && $stable(sda_o)));

  // R10
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> idle);
endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_pop,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              addr_ten,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic              scl_mon,
  output logic              go,
  output sym_e              op,
  output logic [BYTE_W-1:0] txb,
  output logic              rd_mode,
  output logic              ack_val,
  output logic              rx_push,
  output logic              done_evt,
  output logic              err_evt
);
  seq_e              st_q, st_n;
  logic              dir_q, dir_n, fresh_q, fresh_n;
  logic              crd_q, crd_n, cstop_q, cstop_n, drop_q, drop_n;
  logic              go_q, go_n, rdm_q, rdm_n, av_q, av_n;
  sym_e              op_q, op_n;
  logic [BYTE_W-1:0] txb_q, txb_n;
  logic              push_q, push_n, done_q, done_n, err_q, err_n;
  logic              fail, pop_c;
  logic [BYTE_W-1:0] hdr_w, hdr_r;

  assign hdr_w = addr_ten ? {5'b11110, tgt_addr[ADDR_W-1:BYTE_W], 1'b0}
                          : {tgt_addr[BYTE_W-2:0], dir_q};
  assign hdr_r = {5'b11110, tgt_addr[ADDR_W-1:BYTE_W], 1'b1};

  always_comb begin
    st_n = st_q; dir_n = dir_q; fresh_n = fresh_q; crd_n = crd_q;
    cstop_n = cstop_q; drop_n = drop_q;
    go_n = 1'b0; op_n = SYM_NONE; txb_n = '0; rdm_n = 1'b0; av_n = 1'b0;
    push_n = 1'b0; done_n = 1'b0; err_n = 1'b0; fail = 1'b0; pop_c = 1'b0;
    case (st_q)
      S_IDLE: if (cmd_valid) begin
        dir_n = cmd_word[CB_RD]; go_n = 1'b1; op_n = SYM_START; st_n = S_STA;
      end
      S_STA, S_RSC: if (eng_done) begin
        go_n = 1'b1; op_n = SYM_BYTE; txb_n = hdr_w; st_n = S_AD1;
      end
      S_AD1: if (eng_done) begin
        if (eng_ack) fail = 1'b1;
        else if (addr_ten) begin
          go_n = 1'b1; op_n = SYM_BYTE; txb_n = tgt_addr[BYTE_W-1:0]; st_n = S_AD2;
        end else begin fresh_n = 1'b1; st_n = S_NEXT; end
      end
      S_AD2: if (eng_done) begin
        if (eng_ack) fail = 1'b1;
        else if (dir_q) begin go_n = 1'b1; op_n = SYM_RSTART; st_n = S_RS10; end
        else begin fresh_n = 1'b1; st_n = S_NEXT; end
      end
      S_RS10: if (eng_done) begin
        go_n = 1'b1; op_n = SYM_BYTE; txb_n = hdr_r; st_n = S_AD3;
      end
      S_AD3: if (eng_done) begin
        if (eng_ack) fail = 1'b1;
        else begin fresh_n = 1'b1; st_n = S_NEXT; end
      end
      S_NEXT: if (cmd_valid) begin
        if (!fresh_q && (cmd_word[CB_RS] || (cmd_word[CB_RD] != dir_q))) begin
          dir_n = cmd_word[CB_RD]; go_n = 1'b1; op_n = SYM_RSTART; st_n = S_RSC;
        end else begin
          pop_c = 1'b1; fresh_n = 1'b0;
          crd_n = cmd_word[CB_RD]; cstop_n = cmd_word[CB_STOP];
          go_n = 1'b1; op_n = SYM_BYTE; txb_n = cmd_word[BYTE_W-1:0];
          rdm_n = cmd_word[CB_RD]; av_n = cmd_word[CB_STOP];
          st_n = S_DAT;
        end
      end
      S_DAT: if (eng_done) begin
        if (!crd_q && eng_ack) begin
          err_n = 1'b1; drop_n = !cstop_q; go_n = 1'b1; op_n = SYM_STOP; st_n = S_STP;
        end else begin
          push_n = crd_q;
          if (cstop_q) begin
            drop_n = 1'b0; go_n = 1'b1; op_n = SYM_STOP; st_n = S_STP;
          end else st_n = S_NEXT;
        end
      end
      S_STP: if (eng_done) begin
        if (drop_q) st_n = S_FLS;
        else begin done_n = 1'b1; st_n = S_IDLE; end
      end
      S_FLS: if (cmd_valid) begin
        pop_c = 1'b1;
        if (cmd_word[CB_STOP]) begin done_n = 1'b1; st_n = S_IDLE; end
      end
      default: st_n = S_IDLE;
    endcase
    if (fail) begin
      err_n = 1'b1; drop_n = 1'b1; go_n = 1'b1; op_n = SYM_STOP; st_n = S_STP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; dir_q <= 1'b0; fresh_q <= 1'b0; crd_q <= 1'b0;
      cstop_q <= 1'b0; drop_q <= 1'b0; go_q <= 1'b0; op_q <= SYM_NONE;
      txb_q <= '0; rdm_q <= 1'b0; av_q <= 1'b0;
      push_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_n; dir_q <= dir_n; fresh_q <= fresh_n; crd_q <= crd_n;
      cstop_q <= cstop_n; drop_q <= drop_n; go_q <= go_n; op_q <= op_n;
      txb_q <= txb_n; rdm_q <= rdm_n; av_q <= av_n;
      push_q <= push_n; done_q <= done_n; err_q <= err_n;
    end
  end

  assign cmd_pop  = pop_c;
  assign go       = go_q;
  assign op       = op_q;
  assign txb      = txb_q;
  assign rd_mode  = rdm_q;
  assign ack_val  = av_q;
  assign rx_push  = push_q;
  assign done_evt = done_q;
  assign err_evt  = err_q;

  // R10
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> cmd_valid);

  // R10
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_push, done_evt, err_evt}));

  // R9
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_NEXT && !cmd_valid) |-> !scl_mon);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_tick,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_pop,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              addr_ten,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              done_evt,
  output logic              err_evt
);
  logic              go, rd_mode, ack_val, eng_done, eng_ack, eng_idle;
  sym_e              op;
  logic [BYTE_W-1:0] txb;

  i2cseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_pop(cmd_pop), .tgt_addr(tgt_addr), .addr_ten(addr_ten),
    .eng_done(eng_done), .eng_ack(eng_ack), .scl_mon(scl_o),
    .go(go), .op(op), .txb(txb), .rd_mode(rd_mode), .ack_val(ack_val),
    .rx_push(rx_push), .done_evt(done_evt), .err_evt(err_evt)
  );

  i2cseq_bus_eng u_eng (
    .clk(clk), .rst_n(rst_n), .tick(step_tick), .go(go), .op(op),
    .tx_byte(txb), .rd_mode(rd_mode), .ack_val(ack_val), .sda_i(sda_i),
    .scl_o(scl_o), .sda_o(sda_o), .done(eng_done), .ack_in(eng_ack),
    .idle(eng_idle), .rx_byte(rx_data)
  );

  // R7
  release_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (scl_o && sda_o));

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && $past(done_evt)) |-> (scl_o && sda_o));
endmodule

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
  localparam logic [10:0] T_S = 11'h200;
  localparam logic [10:0] T_P = 11'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int   tdiv = 0;
  logic tick_en = 1'b1;
  logic tick;
  always @(posedge clk) tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
  assign tick = tick_en && (tdiv == 3);

  logic [10:0] cq [0:63];
  int qh = 0, qt = 0;
  logic cmd_valid, cmd_pop;
  logic [10:0] cmd_word;
  assign cmd_valid = (qh != qt);
  assign cmd_word  = cq[qh % 64];
  always @(posedge clk) if (cmd_pop) qh <= qh + 1;

  logic [9:0] tgt_addr = '0;
  logic addr_ten = 1'b0;
  logic scl_o, sda_o, rx_push, done_evt, err_evt;
  logic [7:0] rx_data;
  logic s_drv = 1'b1;
  logic sda_bus;
  assign sda_bus = sda_o & s_drv;

  i2c_cmd_seq u_i2c_cmd_seq (
    .clk(clk), .rst_n(rst_n), .step_tick(tick), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .cmd_pop(cmd_pop), .tgt_addr(tgt_addr),
    .addr_ten(addr_ten), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_bus),
    .rx_push(rx_push), .rx_data(rx_data), .done_evt(done_evt), .err_evt(err_evt)
  );

  // target model and bus log
  logic ps = 1'b1, pd = 1'b1, rdm = 1'b0, mnack = 1'b0;
  int bc = 0, bidx = 0, nbytes = 0, nslv = 0, nack_at = -1;
  logic [7:0] sh = '0, txb = '0;
  logic [10:0] tok [0:63];
  int ntok = 0;
  logic [7:0] rxl [0:15];
  int nrx = 0, ndone = 0, nerr = 0;
  time err_t = 0, done_t = 0;

  always @(posedge clk) begin
    logic d;
    d = sda_bus;
    if (rst_n) begin
      if (scl_o && ps && pd && !d) begin
        tok[ntok % 64] = T_S; ntok++; bc = 0; bidx = 0; rdm = 0; mnack = 0; s_drv = 1;
      end else if (scl_o && ps && !pd && d) begin
        tok[ntok % 64] = T_P; ntok++; bc = 0; s_drv = 1;
      end else if (scl_o && !ps) begin
        if (bc < 8) sh = {sh[6:0], d};
        else begin tok[ntok % 64] = {2'b00, d, sh}; ntok++; mnack = d; nbytes++; end
        bc++;
      end else if (!scl_o && ps) begin
        if (bc == 8) begin
          if (bidx == 0) rdm = sh[0];
          if (bidx == 0 || !rdm) s_drv = (nbytes == nack_at) ? 1'b1 : 1'b0;
          else s_drv = 1'b1;
        end else if (bc == 9) begin
          bc = 0; bidx++;
          if (rdm && !mnack) begin txb = 8'h3C + 8'(nslv); nslv++; s_drv = txb[7]; end
          else s_drv = 1'b1;
        end else if (bc >= 1 && bc <= 7 && rdm && bidx > 0) begin
          s_drv = txb[7 - bc];
        end
      end
      if (rx_push) begin rxl[nrx % 16] = rx_data; nrx++; end
      if (err_evt) begin nerr++; err_t = $time; end
      if (done_evt) begin ndone++; done_t = $time; end
    end
    ps = scl_o; pd = d;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [10:0] w);
    @(negedge clk);
    cq[qt % 64] = w;
    qt = qt + 1;
  endtask

  task automatic clr();
    @(negedge clk);
    ntok = 0; nrx = 0; ndone = 0; nerr = 0; nbytes = 0; nslv = 0;
  endtask

  task automatic wait_done(input string req);
    int w;
    w = 0;
    while (ndone == 0 && w < 20000) begin @(negedge clk); w++; end
    chk(ndone == 1, req, ndone, 1);
  endtask

  task automatic ctok(input int i, input logic [10:0] e, input string req);
    chk(ntok > i && tok[i] == e, req, (ntok > i) ? int'(tok[i]) : -1, int'(e));
  endtask

  typedef struct packed { logic [6:0] a; logic rd; logic [7:0] d; } vec_t;
  localparam vec_t VEC [6] = '{
    '{7'h50, 1'b0, 8'hA5}, '{7'h7F, 1'b0, 8'h00}, '{7'h00, 1'b0, 8'hFF},
    '{7'h2A, 1'b1, 8'h00}, '{7'h13, 1'b1, 8'hEE}, '{7'h61, 1'b0, 8'h5A}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(scl_o && sda_o, "R1 bus released in reset", {scl_o, sda_o}, 3);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(scl_o && sda_o && !cmd_pop && !rx_push && !done_evt && !err_evt,
        "R1 quiet after reset", {scl_o, sda_o, cmd_pop, done_evt, err_evt}, 5'b11000);
    chk(ntok == 0, "R1 no bus activity", ntok, 0);

    // R2 R3 R6 R7 single-word table
    foreach (VEC[k]) begin
      clr();
      tgt_addr = {3'b000, VEC[k].a}; addr_ten = 1'b0;
      push({1'b0, 1'b1, VEC[k].rd, VEC[k].d});
      wait_done("R7 table done");
      chk(ntok == 4, "R7 table token count", ntok, 4);
      ctok(0, T_S, "R3 table start");
      ctok(1, {3'b000, VEC[k].a, VEC[k].rd}, "R3 table address");
      if (VEC[k].rd) begin
        ctok(2, {3'b001, 8'h3C}, "R6 read byte with NACK");
        chk(nrx == 1 && rxl[0] == 8'h3C, "R6 rx push", rxl[0], 8'h3C);
      end else begin
        ctok(2, {3'b000, VEC[k].d}, "R2 write byte");
        chk(nrx == 0, "R2 no push on write", nrx, 0);
      end
      ctok(3, T_P, "R7 table stop");
    end

    // R5 direction change: write, write, read+stop
    clr(); tgt_addr = 10'h021;
    push(11'h011); push(11'h022); push(11'h300);
    wait_done("R5 dir change done");
    chk(ntok == 8, "R5 dir token count", ntok, 8);
    ctok(1, {3'b000, 8'h42}, "R5 first address");
    ctok(3, {3'b000, 8'h22}, "R5 second byte");
    ctok(4, T_S, "R5 repeated start on direction change");
    ctok(5, {3'b000, 8'h43}, "R5 read address");
    ctok(6, {3'b001, 8'h3C}, "R6 read NACK at stop");
    ctok(7, T_P, "R7 stop");

    // R5 repeated-start flag; flag on first byte ignored
    clr();
    push(11'h4AA); push(11'h6BB);
    wait_done("R5 rs flag done");
    chk(ntok == 7, "R5 rs token count", ntok, 7);
    ctok(2, {3'b000, 8'hAA}, "R5 rs ignored on first byte");
    ctok(3, T_S, "R5 repeated start from flag");
    ctok(4, {3'b000, 8'h42}, "R5 address after flag");
    ctok(5, {3'b000, 8'hBB}, "R5 byte after flag");

    // R6 two reads: ACK then NACK
    clr(); tgt_addr = 10'h015;
    push(11'h100); push(11'h300);
    wait_done("R6 two reads done");
    ctok(2, {3'b000, 8'h3C}, "R6 ACK on non-final read");
    ctok(3, {3'b001, 8'h3D}, "R6 NACK on final read");
    chk(nrx == 2 && rxl[1] == 8'h3D, "R6 second rx byte", rxl[1], 8'h3D);

    // R4 10-bit write
    clr(); tgt_addr = 10'h2B5; addr_ten = 1'b1;
    push(11'h277);
    wait_done("R4 ten write done");
    chk(ntok == 5, "R4 ten write token count", ntok, 5);
    ctok(1, {3'b000, 8'hF4}, "R4 ten write header");
    ctok(2, {3'b000, 8'hB5}, "R4 ten low address");
    ctok(3, {3'b000, 8'h77}, "R4 ten data");

    // R4 10-bit read
    clr();
    push(11'h300);
    wait_done("R4 ten read done");
    chk(ntok == 7, "R4 ten read token count", ntok, 7);
    ctok(3, T_S, "R4 ten read repeated start");
    ctok(4, {3'b000, 8'hF5}, "R4 ten read header");
    ctok(5, {3'b001, 8'h3C}, "R4 ten read data");
    addr_ten = 1'b0;

    // R8 address NACK with flush
    clr(); tgt_addr = 10'h033; nack_at = 0;
    push(11'h001); push(11'h202);
    wait_done("R8 addr nack done");
    chk(nerr == 1 && err_t < done_t, "R8 error before complete", nerr, 1);
    chk(ntok == 3, "R8 addr nack token count", ntok, 3);
    ctok(1, {3'b001, 8'h66}, "R8 address NACKed");
    ctok(2, T_P, "R8 stop after NACK");
    chk(!cmd_valid, "R8 commands flushed", qt - qh, 0);
    clr(); nack_at = -1;
    push(11'h244);
    wait_done("R8 recovery done");
    ctok(2, {3'b000, 8'h44}, "R8 next transaction runs");

    // R8 data NACK
    clr(); nack_at = 1;
    push(11'h010); push(11'h020); push(11'h230);
    wait_done("R8 data nack done");
    chk(nerr == 1, "R8 data nack error", nerr, 1);
    chk(ntok == 4, "R8 data nack token count", ntok, 4);
    ctok(3, T_P, "R8 stop after data NACK");
    chk(!cmd_valid, "R8 data flush", qt - qh, 0);
    nack_at = -1;

    // R9 hold SCL low on empty queue
    clr();
    push(11'h009);
    repeat (600) @(negedge clk);
    chk(scl_o == 1'b0, "R9 SCL held low", scl_o, 0);
    chk(ntok == 3 && ndone == 0, "R9 no stop while empty", ntok, 3);
    push(11'h20A);
    wait_done("R9 resume done");
    ctok(3, {3'b000, 8'h0A}, "R9 resumed byte");
    ctok(4, T_P, "R9 stop after resume");

    // R11 frozen strobe
    clr();
    push(11'h2C3);
    repeat (200) @(negedge clk);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    begin
      logic s0, d0;
      s0 = scl_o; d0 = sda_o;
      repeat (300) @(negedge clk);
      chk(scl_o == s0 && sda_o == d0, "R11 bus frozen without strobe", {scl_o, sda_o}, {s0, d0});
    end
    tick_en = 1'b1;
    wait_done("R11 resume done");
    ctok(2, {3'b000, 8'hC3}, "R11 byte intact");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule